// File: doc/BRIEF.md
# Reaction Trial Controller

This block runs repeated reaction-time trials for a person at a panel of slide switches. Each trial opens with a blank phase of fixed length. The controller then asks an external generator for a fresh pair of octal digits and enables their display. From that moment it counts elapsed time in tenths of a second. The person enters the sum of the two digits as a 4-bit binary value and raises a submit switch.

The controller then shows either the measured time or an error code. Error 1 means a wrong answer. Error 2 means no submission arrived within the timeout. Each result stays visible until the person clears it with the submit switch, and the next trial then begins with a new blank phase.

The switches are mechanical and bounce. Both the submit and answer inputs pass through two-flop synchronisers. Every change of the submit level must then hold for a settle window before the controller acts on it. The block holds its own tenth-second prescaler and elapsed counter. All display-facing outputs are decoded from the state register alone, and seven-segment drivers sit outside the block.

Top module: `reaction_trial`

## Requirements
- R1: While reset is held and on the first sample after it, newPairReq, digitsShow and resultShow are 0, errorCode is 0 and elapsedTenths is 0. The reset state has the all-zero encoding.
- R2: digitsShow rises exactly BLANK_TICKS*TICK_CYCLES+3 clock cycles after either of two points. One is the release of reset. The other is the cycle in which digitsShow falls at the end of a cleared trial.
- R3: Each trial raises newPairReq for exactly one cycle, and digitsShow rises in the cycle right after it.
- R4: A submission is confirmed when submit has held high for SETTLE_CYCLES cycles. The synchronised submit reaches the controller 3 cycles after the pin changes. If the answer is correct at confirmation, resultShow rises with errorCode 0. elapsedTenths then holds, frozen, the whole number of TICK_CYCLES periods that passed from the rise of digitsShow to the confirmation.
- R5: A confirmed submission with a wrong answer shows errorCode 1. Error codes are: 0 for none, 1 for a wrong answer, 2 for a timeout. The code stays until submit has held low for SETTLE_CYCLES cycles, and the trial then ends.
- R6: If no submission is confirmed before elapsedTenths reaches TIMEOUT_TICKS, errorCode becomes 2 one cycle after it does. A submission confirmed earlier still yields a time.
- R7: Error 2 clears only after submit has held high for a settle window and then held low for a settle window. A high level alone does not clear it.
- R8: A submit pulse or dip shorter than SETTLE_CYCLES has no effect. It causes no submission, no clearing of a time or error 1, and no step in the error-2 clearing sequence.
- R9: The answer is the 4-bit value compared against the zero-extended sum of digitPair[5:3] and digitPair[2:0]. It is taken once, at confirmation, and later changes of answerIn do not alter the displayed result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| submitIn | input | 1 | Raw submit switch, asynchronous, may bounce |
| answerIn | input | 4 | Raw binary answer switches, asynchronous |
| digitPair | input | 6 | Current digit pair from the generator, upper digit in [5:3] |
| newPairReq | output | 1 | One-cycle request for a fresh digit pair |
| digitsShow | output | 1 | Enables the digit-pair display |
| elapsedTenths | output | CNT_W | Elapsed time in tenth-second ticks |
| errorCode | output | 2 | 0 none, 1 wrong answer, 2 timeout |
| resultShow | output | 1 | Enables the time/error display |

## Verification
On every cycle, the assertions check that the request pulse lasts one cycle and is followed at once by the digit display. They also check that a shown time never moves, that error 1 and a shown time agree with the answer comparison one cycle earlier, that error 2 appears only when the counter stands at the timeout, and that error 2 is left only with submit low. Only the bench scenarios can show exact cycle counts. These are the blank length, the tick count seen at several submit delays, and the boundary just inside the timeout. The same holds for bounce rejection, the full clearing sequences, and the answer check over every one of the 64 digit pairs.

// File: rtl/reaction_trial_pkg.sv
package reaction_trial_pkg;

  typedef enum logic [3:0] {
    ST_IDLE      = 4'd0,
    ST_BLANK     = 4'd1,
    ST_REQ       = 4'd2,
    ST_WAIT      = 4'd3,
    ST_CONF      = 4'd4,
    ST_SHOW      = 4'd5,
    ST_SHOW_REL  = 4'd6,
    ST_ERR1      = 4'd7,
    ST_ERR1_REL  = 4'd8,
    ST_ERR2_HI   = 4'd9,
    ST_ERR2_HIC  = 4'd10,
    ST_ERR2_LO   = 4'd11,
    ST_ERR2_LOC  = 4'd12
  } trialState_t;

  typedef struct packed {
    logic timerClr;
    logic timerRun;
    logic settleClr;
    logic settleRun;
  } ctlStrobes_t;

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_WRONG   = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;

endpackage

// File: rtl/reaction_trial_datapath.sv
module reaction_trial_datapath
  import reaction_trial_pkg::*;
#(
  parameter int TICK_CYCLES   = 5_000_000,
  parameter int SETTLE_CYCLES = 1_000_000,
  parameter int CNT_W         = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             submitRaw,
  input  logic [3:0]       answerRaw,
  input  logic [5:0]       digitPair,
  input  ctlStrobes_t      ctl,
  output logic             subLvl,
  output logic             answerOk,
  output logic             settleDone,
  output logic [CNT_W-1:0] elapsed
);

  localparam int DIV_W = $clog2(TICK_CYCLES + 1);
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_CYCLES - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);

  logic             subMeta, subSync;
  logic [3:0]       ansMeta, ansSync;
  logic [DIV_W-1:0] divCnt;
  logic [SET_W-1:0] settleCnt;
  logic [3:0]       digitSum;

  // two-stage synchronisers for the switch inputs
  always_ff @(posedge clk) begin
    if (rst) begin
      subMeta <= 1'b0;
      subSync <= 1'b0;
      ansMeta <= '0;
      ansSync <= '0;
    end else begin
      subMeta <= submitRaw;
      subSync <= subMeta;
      ansMeta <= answerRaw;
      ansSync <= ansMeta;
    end
  end

  // tenth-second prescaler and saturating elapsed counter
  always_ff @(posedge clk) begin
    if (rst || ctl.timerClr) begin
      divCnt  <= '0;
      elapsed <= '0;
    end else if (ctl.timerRun) begin
      if (divCnt == DIV_LAST) begin
        divCnt <= '0;
        if (elapsed != '1) elapsed <= elapsed + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  // settle window for submit level changes
  always_ff @(posedge clk) begin
    if (rst || ctl.settleClr) settleCnt <= '0;
    else if (ctl.settleRun && settleCnt != SET_LAST) settleCnt <= settleCnt + 1'b1;
  end

  assign digitSum   = {1'b0, digitPair[5:3]} + {1'b0, digitPair[2:0]};
  assign answerOk   = (ansSync == digitSum);
  assign settleDone = (settleCnt == SET_LAST);
  assign subLvl     = subSync;

  // R4: with the timer neither running nor cleared, the count cannot move
  a_r4_count_holds: assert property (@(posedge clk) disable iff (rst)
    (!ctl.timerRun && !ctl.timerClr) |=> $stable(elapsed));

  // R4: the count never steps while the prescaler is mid-period
  a_r4_tick_period: assert property (@(posedge clk) disable iff (rst)
    (ctl.timerRun && !ctl.timerClr && divCnt != DIV_LAST) |=> $stable(elapsed));

endmodule

// File: rtl/reaction_trial_ctrl.sv
module reaction_trial_ctrl
  import reaction_trial_pkg::*;
#(
  parameter int BLANK_TICKS   = 20,
  parameter int TIMEOUT_TICKS = 80,
  parameter int CNT_W         = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             subLvl,
  input  logic             answerOk,
  input  logic             settleDone,
  input  logic [CNT_W-1:0] elapsed,
  output ctlStrobes_t      ctl,
  output logic             newPair,
  output logic             digitsOn,
  output logic             resultOn,
  output logic [1:0]       errCode
);

  localparam logic [CNT_W-1:0] BLANK_V   = CNT_W'(BLANK_TICKS);
  localparam logic [CNT_W-1:0] TIMEOUT_V = CNT_W'(TIMEOUT_TICKS);

  trialState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:     nextState = ST_BLANK;
      ST_BLANK:    if (elapsed == BLANK_V) nextState = ST_REQ;
      ST_REQ:      nextState = ST_WAIT;
      ST_WAIT:     if (elapsed == TIMEOUT_V) nextState = ST_ERR2_HI;
                   else if (subLvl)          nextState = ST_CONF;
      ST_CONF:     if (elapsed == TIMEOUT_V) nextState = ST_ERR2_HI;
                   else if (!subLvl)         nextState = ST_WAIT;
                   else if (settleDone)      nextState = answerOk ? ST_SHOW : ST_ERR1;
      ST_SHOW:     if (!subLvl) nextState = ST_SHOW_REL;
      ST_SHOW_REL: if (subLvl) nextState = ST_SHOW;
                   else if (settleDone) nextState = ST_IDLE;
      ST_ERR1:     if (!subLvl) nextState = ST_ERR1_REL;
      ST_ERR1_REL: if (subLvl) nextState = ST_ERR1;
                   else if (settleDone) nextState = ST_IDLE;
      ST_ERR2_HI:  if (subLvl) nextState = ST_ERR2_HIC;
      ST_ERR2_HIC: if (!subLvl) nextState = ST_ERR2_HI;
                   else if (settleDone) nextState = ST_ERR2_LO;
      ST_ERR2_LO:  if (!subLvl) nextState = ST_ERR2_LOC;
      ST_ERR2_LOC: if (subLvl) nextState = ST_ERR2_LO;
                   else if (settleDone) nextState = ST_IDLE;
      default:     nextState = ST_IDLE;
    endcase
  end

  // Moore outputs: decoded from the state register only
  always_comb begin
    ctl      = '{timerClr: 1'b0, timerRun: 1'b0, settleClr: 1'b1, settleRun: 1'b0};
    newPair  = 1'b0;
    digitsOn = 1'b0;
    resultOn = 1'b0;
    errCode  = ERR_NONE;
    unique case (state)
      ST_IDLE:  ctl.timerClr = 1'b1;
      ST_BLANK: ctl.timerRun = 1'b1;
      ST_REQ: begin
        newPair      = 1'b1;
        ctl.timerClr = 1'b1;
      end
      ST_WAIT: begin
        digitsOn     = 1'b1;
        ctl.timerRun = 1'b1;
      end
      ST_CONF: begin
        digitsOn      = 1'b1;
        ctl.timerRun  = 1'b1;
        ctl.settleClr = 1'b0;
        ctl.settleRun = 1'b1;
      end
      ST_SHOW, ST_SHOW_REL: begin
        digitsOn      = 1'b1;
        resultOn      = 1'b1;
        ctl.settleClr = (state == ST_SHOW);
        ctl.settleRun = (state == ST_SHOW_REL);
      end
      ST_ERR1, ST_ERR1_REL: begin
        digitsOn      = 1'b1;
        resultOn      = 1'b1;
        errCode       = ERR_WRONG;
        ctl.settleClr = (state == ST_ERR1);
        ctl.settleRun = (state == ST_ERR1_REL);
      end
      ST_ERR2_HI, ST_ERR2_HIC, ST_ERR2_LO, ST_ERR2_LOC: begin
        digitsOn      = 1'b1;
        resultOn      = 1'b1;
        errCode       = ERR_TIMEOUT;
        ctl.settleClr = (state == ST_ERR2_HI) || (state == ST_ERR2_LO);
        ctl.settleRun = (state == ST_ERR2_HIC) || (state == ST_ERR2_LOC);
      end
      default: ctl.timerClr = 1'b1;
    endcase
  end

  a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
    newPair |=> !newPair);

  a_r3_req_then_show: assert property (@(posedge clk) disable iff (rst)
    newPair |=> digitsOn);

  a_r5_wrong_needs_mismatch: assert property (@(posedge clk) disable iff (rst)
    $rose(errCode == ERR_WRONG) |-> !$past(answerOk));

  a_r4_time_needs_match: assert property (@(posedge clk) disable iff (rst)
    $rose(resultOn && errCode == ERR_NONE) |-> $past(answerOk));

  a_r6_timeout_at_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(errCode == ERR_TIMEOUT) |-> ($past(elapsed) == TIMEOUT_V));

  a_r7_err2_leaves_low: assert property (@(posedge clk) disable iff (rst)
    $fell(errCode == ERR_TIMEOUT) |-> !$past(subLvl));

endmodule

// File: rtl/reaction_trial.sv
module reaction_trial
  import reaction_trial_pkg::*;
#(
  parameter int TICK_CYCLES   = 5_000_000,
  parameter int SETTLE_CYCLES = 1_000_000,
  parameter int BLANK_TICKS   = 20,
  parameter int TIMEOUT_TICKS = 80,
  localparam int CNT_W        = $clog2(TIMEOUT_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             submitIn,
  input  logic [3:0]       answerIn,
  input  logic [5:0]       digitPair,
  output logic             newPairReq,
  output logic             digitsShow,
  output logic [CNT_W-1:0] elapsedTenths,
  output logic [1:0]       errorCode,
  output logic             resultShow
);

  ctlStrobes_t ctl;
  logic        subLvl, answerOk, settleDone;

  reaction_trial_datapath #(
    .TICK_CYCLES  (TICK_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .CNT_W        (CNT_W)
  ) u_datapath (
    .clk       (clk),
    .rst       (rst),
    .submitRaw (submitIn),
    .answerRaw (answerIn),
    .digitPair (digitPair),
    .ctl       (ctl),
    .subLvl    (subLvl),
    .answerOk  (answerOk),
    .settleDone(settleDone),
    .elapsed   (elapsedTenths)
  );

  reaction_trial_ctrl #(
    .BLANK_TICKS  (BLANK_TICKS),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .CNT_W        (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .subLvl    (subLvl),
    .answerOk  (answerOk),
    .settleDone(settleDone),
    .elapsed   (elapsedTenths),
    .ctl       (ctl),
    .newPair   (newPairReq),
    .digitsOn  (digitsShow),
    .resultOn  (resultShow),
    .errCode   (errorCode)
  );

  // R4: a displayed time stays frozen while it is shown
  a_r4_shown_time_stable: assert property (@(posedge clk) disable iff (rst)
    (resultShow && errorCode == ERR_NONE && $past(resultShow)) |-> $stable(elapsedTenths));

endmodule

// File: tb/reaction_trial_bench.sv
module reaction_trial_bench;

  localparam int T       = 50;
  localparam int S       = 10;
  localparam int BLANK   = 20;
  localparam int TMO     = 80;
  localparam int CW      = $clog2(TMO + 1);
  localparam int BLANK_LEN = BLANK * T + 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          submitIn = 1'b0;
  logic [3:0]    answerIn = '0;
  logic [5:0]    digitPair = '0;
  logic          newPairReq, digitsShow, resultShow;
  logic [CW-1:0] elapsedTenths;
  logic [1:0]    errorCode;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  reaction_trial #(
    .TICK_CYCLES  (T),
    .SETTLE_CYCLES(S),
    .BLANK_TICKS  (BLANK),
    .TIMEOUT_TICKS(TMO)
  ) u_reaction_trial (
    .clk          (clk),
    .rst          (rst),
    .submitIn     (submitIn),
    .answerIn     (answerIn),
    .digitPair    (digitPair),
    .newPairReq   (newPairReq),
    .digitsShow   (digitsShow),
    .elapsedTenths(elapsedTenths),
    .errorCode    (errorCode),
    .resultShow   (resultShow)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts cycles until digitsShow rises; checks blank length and request pulse
  task automatic waitShow(string tag);
    int n = 0;
    int reqs = 0;
    bit prevReq = 1'b0;
    bit lastReq = 1'b0;
    while (!digitsShow && n < BLANK_LEN + 50) begin
      tick();
      n++;
      lastReq = prevReq;
      prevReq = newPairReq;
      if (newPairReq) reqs++;
    end
    check(n == BLANK_LEN, {"R2 blank length ", tag}, n, BLANK_LEN);
    check(reqs == 1, {"R3 request pulses ", tag}, reqs, 1);
    check(lastReq == 1'b1, {"R3 request just before show ", tag}, lastReq, 1);
  endtask

  task automatic waitResult(int limit);
    int n = 0;
    while (!resultShow && n < limit) begin
      tick();
      n++;
    end
  endtask

  task automatic releaseAndEnd(string tag);
    int n = 0;
    submitIn = 1'b0;
    while (digitsShow && n < 100) begin
      tick();
      n++;
    end
    check(!digitsShow && !resultShow, {"R5 trial ends after release ", tag}, digitsShow, 0);
  endtask

  // one full trial: pair, correct or wrong answer, submit after delay cycles
  task automatic runTrial(int pair, bit good, int delay, string tag);
    int sum = (pair >> 3) + (pair & 7);
    int expK;
    digitPair = pair[5:0];
    answerIn  = good ? sum[3:0] : 4'((sum + 1) & 15);
    waitShow(tag);
    repeat (delay) tick();
    submitIn = 1'b1;
    waitResult(100);
    expK = (delay + 3 + S) / T;
    if (good) begin
      check(resultShow && errorCode == 2'd0, {"R9 correct sum accepted ", tag}, errorCode, 0);
      check(elapsedTenths == expK, {"R4 elapsed tenths ", tag}, elapsedTenths, expK);
    end else begin
      check(resultShow && errorCode == 2'd1, {"R5 wrong sum gives error 1 ", tag}, errorCode, 1);
    end
    repeat (5) tick();
    releaseAndEnd(tag);
  endtask

  initial begin
    repeat (3) tick();
    check(!newPairReq && !digitsShow && !resultShow, "R1 outputs idle in reset", digitsShow, 0);
    check(errorCode == 0 && elapsedTenths == 0, "R1 code and count zero in reset", errorCode, 0);
    rst = 1'b0;
    tick();
    check(!digitsShow && !resultShow && errorCode == 0, "R1 idle after reset", resultShow, 0);
    // restart count cleanly: a fresh reset so waitShow starts right after release
    rst = 1'b1;
    tick();
    rst = 1'b0;

    // R4/R9: answer sampled once; later switch changes ignored
    digitPair = 6'o53;
    answerIn  = 4'd8;
    waitShow("first");
    repeat (2 * T + 15) tick();
    submitIn = 1'b1;
    waitResult(100);
    check(errorCode == 0 && elapsedTenths == 2, "R4 time after two ticks", elapsedTenths, 2);
    answerIn = 4'd3;
    repeat (20) tick();
    check(resultShow && errorCode == 0 && elapsedTenths == 2, "R9 answer change ignored", errorCode, 0);
    // R8: short dip of submit does not clear the time
    submitIn = 1'b0;
    repeat (3) tick();
    submitIn = 1'b1;
    repeat (30) tick();
    check(resultShow && errorCode == 0, "R8 short dip keeps time", resultShow, 1);
    releaseAndEnd("first");

    // R8: short submit pulse while waiting is not a submission
    digitPair = 6'o77;
    answerIn  = 4'd14;
    waitShow("glitch");
    repeat (T + 15) tick();
    submitIn = 1'b1;
    repeat (3) tick();
    submitIn = 1'b0;
    repeat (40) tick();
    check(!resultShow && digitsShow, "R8 short pulse ignored", resultShow, 0);
    repeat (T - 40 - 3) tick();
    submitIn = 1'b1;
    waitResult(100);
    check(errorCode == 0 && elapsedTenths == 2, "R4 time after ignored pulse", elapsedTenths, 2);
    releaseAndEnd("glitch");

    // R5/R8: error 1 survives a short dip, clears on settled release
    digitPair = 6'o12;
    answerIn  = 4'd9;
    waitShow("err1");
    repeat (15) tick();
    submitIn = 1'b1;
    waitResult(100);
    check(errorCode == 1, "R5 error 1 shown", errorCode, 1);
    submitIn = 1'b0;
    repeat (3) tick();
    submitIn = 1'b1;
    repeat (30) tick();
    check(resultShow && errorCode == 1, "R8 error 1 kept after dip", errorCode, 1);
    releaseAndEnd("err1");

    // R6: submission confirmed just inside the timeout still gives a time
    runTrial(6'o34, 1'b1, TMO * T - 40, "late submit");

    // R6/R7: timeout exactly at the limit, then the two-step clear
    digitPair = 6'o00;
    answerIn  = 4'd0;
    waitShow("timeout");
    repeat (TMO * T) tick();
    check(errorCode == 0 && !resultShow, "R6 no error before limit", errorCode, 0);
    tick();
    check(errorCode == 2 && resultShow, "R6 error 2 at limit", errorCode, 2);
    submitIn = 1'b1;
    repeat (3) tick();
    submitIn = 1'b0;
    repeat (30) tick();
    check(errorCode == 2, "R8 short high not a clear step", errorCode, 2);
    submitIn = 1'b1;
    repeat (40) tick();
    check(errorCode == 2 && resultShow, "R7 high alone keeps error 2", errorCode, 2);
    submitIn = 1'b0;
    repeat (3) tick();
    submitIn = 1'b1;
    repeat (30) tick();
    check(errorCode == 2, "R8 short low keeps error 2", errorCode, 2);
    releaseAndEnd("R7 timeout clear");

    // R9/R4/R5: every digit pair, correct or wrong, varied delays
    for (int p = 0; p < 64; p++) begin
      runTrial(p, (p % 3) != 0, (p % 4) * T + 15, $sformatf("pair %0d", p));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule